// File: doc/BRIEF.md
# Converter Result Window Detector

This block watches each new result coming out of an analog-to-digital converter and compares it against two programmable limits, a greater-than limit and a less-than limit. When a result meets the window condition, the block sets a sticky flag and raises an interrupt request for one cycle. Software can use the request as an interrupt source, or it can poll the flag and later clear it with a pulse.

No mode bit chooses whether the block reports results inside or outside the window. The relative order of the two limits decides it. If the less-than limit is above the greater-than limit, the window is the open band between them, and a result inside that band qualifies. Otherwise a result qualifies when it lies above the greater-than limit or below the less-than limit. All comparisons are strict and unsigned, and the word width is a parameter that defaults to 12 bits.

Top module: `adcwin_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `win_flag` and `win_irq` are 0.
- R2: When `lim_lt` > `lim_gt` (unsigned), a result qualifies exactly when `lim_gt` < `res_data` < `lim_lt`.
- R3: When `lim_lt` <= `lim_gt` (unsigned), a result qualifies exactly when `res_data` > `lim_gt` or `res_data` < `lim_lt`.
- R4: A result equal to either limit never qualifies, including when the two limits are equal.
- R5: `win_flag` goes to 1 on the clock edge that samples a qualifying result with `res_valid` high. It then stays at 1 until a clear.
- R6: A `flag_clr` pulse makes `win_flag` 0 after the next edge. If a qualifying result is sampled on that same edge, the flag becomes 1 instead, so a set wins over a clear.
- R7: `win_irq` is 1 for exactly the one cycle after each sampled qualifying result. Back-to-back qualifying results keep it high on consecutive cycles.
- R8: When `res_valid` is 0, `res_data` has no effect: `win_irq` stays 0 and `win_flag` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_data | input | W | Converter result word |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| lim_gt | input | W | Greater-than limit |
| lim_lt | input | W | Less-than limit |
| flag_clr | input | 1 | Pulse that clears the sticky flag |
| win_flag | output | 1 | Sticky window flag |
| win_irq | output | 1 | One-cycle interrupt request per qualifying result |

## Verification
The comparison is combinational, and both outputs are registered once. A result presented with its strobe before a rising edge therefore shows on `win_flag` and `win_irq` just after that edge, and a clear takes effect on the same edge. The bench drives every input on the falling edge and checks one time unit after the following rising edge. It compares each output against a model flag and model request, which it computes from the limit order. Directed cases cover equal limits, results equal to a limit, set and clear on the same edge, and strobe-low data, alongside seeded random results and limits.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;

  // The window is inside-sense when the less-than limit lies strictly above the greater-than limit.
  function automatic logic win_inside(input logic [31:0] gt, input logic [31:0] lt);
    return lt > gt;
  endfunction

  // Qualification of a single result against the two limits.
  function automatic logic win_hit(input logic [31:0] res,
                                   input logic [31:0] gt,
                                   input logic [31:0] lt);
    logic above, below;
    above = res > gt;
    below = res < lt;
    if (win_inside(gt, lt)) return above && below;
    else                    return above || below;
  endfunction

endpackage

// File: rtl/adcwin_cmp.sv
module adcwin_cmp #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res_data,
  input  logic         res_valid,
  input  logic [W-1:0] lim_gt,
  input  logic [W-1:0] lim_lt,
  output logic         hit_qual
);
  import adcwin_pkg::*;

  localparam int PAD = 32 - W;

  logic [31:0] res_w, gt_w, lt_w;
  logic        inside_mode;
  logic        raw_hit;

  assign res_w       = {{PAD{1'b0}}, res_data};
  assign gt_w        = {{PAD{1'b0}}, lim_gt};
  assign lt_w        = {{PAD{1'b0}}, lim_lt};
  assign inside_mode = win_inside(gt_w, lt_w);
  assign raw_hit     = win_hit(res_w, gt_w, lt_w);
  assign hit_qual    = res_valid & raw_hit;

  // R2: in inside mode, a hit lies between the limits
  a_r2_inside_band: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_qual && inside_mode) |-> (res_data > lim_gt && lim_lt > res_data));

  // R3: in outside mode, a hit is beyond one limit
  a_r3_outside_band: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_qual && !inside_mode) |-> (!(res_data <= lim_gt && res_data >= lim_lt)));

  // R4: a result equal to a limit is never a hit
  a_r4_equal_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_data == lim_gt || res_data == lim_lt) |-> !raw_hit);

  // R8: no strobe, no qualified hit
  a_r8_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !hit_qual);

endmodule

// File: rtl/adcwin_flag.sv
module adcwin_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_qual,
  input  logic flag_clr,
  output logic win_flag,
  output logic win_irq
);

  logic flag_next;

  // set has priority over clear
  always_comb begin
    flag_next = win_flag;
    if (flag_clr) flag_next = 1'b0;
    if (hit_qual) flag_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_flag <= 1'b0;
      win_irq  <= 1'b0;
    end else begin
      win_flag <= flag_next;
      win_irq  <= hit_qual;
    end
  end

  // R5: flag holds without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !flag_clr) |=> win_flag);

  // R5/R6: a qualifying result always leaves the flag set, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_qual |=> win_flag);

  // R6: a clear without a hit drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit_qual) |=> !win_flag);

  // R7: request follows each hit for one cycle
  a_r7_irq_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_qual |=> win_irq);

  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_qual |=> !win_irq);

  // R8: the flag only rises because of a hit
  a_r8_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_flag && !hit_qual) |=> !win_flag);

endmodule

// File: rtl/adcwin_detect.sv
module adcwin_detect #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res_data,
  input  logic         res_valid,
  input  logic [W-1:0] lim_gt,
  input  logic [W-1:0] lim_lt,
  input  logic         flag_clr,
  output logic         win_flag,
  output logic         win_irq
);

  logic hit_qual;

  adcwin_cmp #(.W(W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_data  (res_data),
    .res_valid (res_valid),
    .lim_gt    (lim_gt),
    .lim_lt    (lim_lt),
    .hit_qual  (hit_qual)
  );

  adcwin_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_qual (hit_qual),
    .flag_clr (flag_clr),
    .win_flag (win_flag),
    .win_irq  (win_irq)
  );

  // R1: outputs idle in the first cycle after reset
  logic rst_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_seen <= 1'b0;
    else        rst_seen <= 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_seen |-> (!win_flag && !win_irq));

  // R7: a request implies the flag is set
  a_r7_irq_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    win_irq |-> win_flag);

endmodule

// File: tb/adcwin_detect_bench.sv
`timescale 1ns/1ps
module adcwin_detect_bench;
  localparam int W = 12;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] res_data = '0;
  logic         res_valid = 1'b0;
  logic [W-1:0] lim_gt = '0;
  logic [W-1:0] lim_lt = '0;
  logic         flag_clr = 1'b0;
  logic         win_flag, win_irq;

  int checks = 0;
  int errors = 0;
  logic m_flag = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcwin_detect #(.W(W)) u_adcwin_detect (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .lim_gt(lim_gt), .lim_lt(lim_lt), .flag_clr(flag_clr),
    .win_flag(win_flag), .win_irq(win_irq)
  );

  // model restated: band test for inside mode, exclusion of closed band for outside mode
  function automatic bit model_hit(int unsigned r, int unsigned g, int unsigned l);
    if (l > g) return (r > g) && (r < l);
    return !((r >= l) && (r <= g));
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // drive on falling edge, check just after the next rising edge
  task automatic step(logic [W-1:0] r, logic v, logic [W-1:0] g, logic [W-1:0] l,
                      logic c, string req);
    bit h;
    @(negedge clk);
    res_data = r; res_valid = v; lim_gt = g; lim_lt = l; flag_clr = c;
    h = v && model_hit(r, g, l);
    if (c) m_flag = 1'b0;
    if (h) m_flag = 1'b1;
    @(posedge clk);
    #1;
    check(req, win_irq, h, "irq");
    check(req, win_flag, m_flag, "flag");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #(CLK_PERIOD * 2);
    check("R1", win_flag, 1'b0, "flag in reset");
    check("R1", win_irq, 1'b0, "irq in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", win_flag, 1'b0, "flag after reset");
    check("R1", win_irq, 1'b0, "irq after reset");

    // R2 inside mode: gt=100, lt=200
    step(12'd150, 1, 12'd100, 12'd200, 0, "R2 inside hit");
    step(12'd0, 0, 12'd100, 12'd200, 1, "R6 clear");
    step(12'd250, 1, 12'd100, 12'd200, 0, "R2 above band");
    step(12'd50, 1, 12'd100, 12'd200, 0, "R2 below band");
    step(12'd101, 1, 12'd100, 12'd200, 0, "R2 just inside");
    step(12'd199, 1, 12'd100, 12'd200, 1, "R6 set wins over clear");
    step(12'd0, 0, 12'd100, 12'd200, 0, "R5 sticky");
    step(12'd0, 0, 12'd100, 12'd200, 1, "R6 clear again");
    // R4 equality
    step(12'd100, 1, 12'd100, 12'd200, 0, "R4 equal gt inside");
    step(12'd200, 1, 12'd100, 12'd200, 0, "R4 equal lt inside");
    step(12'd300, 1, 12'd300, 12'd300, 0, "R4 equal both limits");
    step(12'd301, 1, 12'd300, 12'd300, 0, "R3 equal limits above");
    step(12'd0, 0, 12'd300, 12'd300, 1, "R6 clear");
    // R3 outside mode: gt=200, lt=100
    step(12'd150, 1, 12'd200, 12'd100, 0, "R3 between no hit");
    step(12'd4095, 1, 12'd200, 12'd100, 0, "R3 max above");
    step(12'd0, 1, 12'd200, 12'd100, 0, "R7 back to back below");
    step(12'd0, 0, 12'd200, 12'd100, 1, "R6 clear");
    // R8 strobe low with qualifying data
    step(12'd4095, 0, 12'd200, 12'd100, 0, "R8 ignored when not valid");
    step(12'd5, 0, 12'd200, 12'd100, 0, "R8 ignored again");

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] g, l, r;
      g = W'($urandom_range(0, 4095));
      l = W'($urandom_range(0, 4095));
      case ($urandom_range(0, 3))
        0: r = g;
        1: r = l;
        default: r = W'($urandom_range(0, 4095));
      endcase
      step(r, 1'($urandom_range(0, 3) != 0), g, l, 1'($urandom_range(0, 4) == 0),
           (l > g) ? "R2 random" : "R3 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule